// File: doc/BRIEF.md
# Ring Bracket Access Checker

This block decides whether one memory reference may go ahead in a segmented memory that is protected by eight nested privilege rings. Ring 0 has the most privilege and ring 7 the least. Each reference brings a segment descriptor with three ring limits: the top of the write bracket, the top of the read bracket and the top of the gate extension. It also brings separate read, write and execute enable flags and a gate count. Alongside the descriptor come the ring that access is judged in, the kind of access and the word offset being touched. From these the block grants the access or raises an access-violation trap with a cause code.

The limits are shared between modes. Writing is open from ring 0 up to the write top. Reading is open from ring 0 up to the read top. Instruction fetch is open only from the write top up to the read top, so the write top also serves as the floor of the execute range. Rings above the read top and up to the gate top form the gate extension. From those rings the segment may be entered only at a gate, and a plain fetch is refused. Gates sit at the start of the segment, so an offset below the gate count is a gate. The block reports whether the ring lies in the gate extension, whether the offset hits a gate, and whether a gated entry would be legal.

The block holds no state, and every output follows its inputs within the same cycle. Address translation and fetching the descriptor are done by the logic around it.

Top module: `ring_bracket_checker`

## Requirements
- R1: With a well-formed descriptor and access kind 1 (write), `allow` is 1 only when `wr_en` is 1 and `val_ring` <= `wr_top`. A write outside that range with the flag set traps with cause 2.
- R2: With a well-formed descriptor and access kind 0 (read), `allow` is 1 only when `rd_en` is 1 and `val_ring` <= `rd_top`. A read outside that range with the flag set traps with cause 1.
- R3: With a well-formed descriptor and access kind 2 (fetch), `allow` is 1 only when `ex_en` is 1 and `wr_top` <= `val_ring` <= `rd_top`. A fetch outside that range with the flag set traps with cause 3, and this includes a fetch from a gate-extension ring.
- R4: `in_gate_ext` is 1 exactly when `rd_top` < `val_ring` <= `gate_top`, whatever the access kind.
- R5: `gate_hit` is 1 exactly when `word_ofs` < `gate_cnt`. `gate_entry_ok` is 1 exactly when `gate_hit`, `in_gate_ext` and `ex_en` are all 1 and the descriptor is well-formed.
- R6: A descriptor with `wr_top` > `rd_top` or `rd_top` > `gate_top` is malformed. It always traps with cause 5 and never allows access or gated entry.
- R7: Access kind 3 is illegal. On a well-formed descriptor it traps with cause 6.
- R8: Cause codes follow a fixed priority: malformed (5), then illegal kind (6), then the flag for the kind off (4), then the bracket miss (1 for read, 2 for write, 3 for fetch). A granted access reports cause 0.
- R9: `trap` is always the inverse of `allow`, and `trap_cause` is 0 exactly when `allow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_top | input | 3 | Top of the write bracket, and floor of the execute range |
| rd_top | input | 3 | Top of the read bracket, and top of the execute range |
| gate_top | input | 3 | Top of the gate extension |
| rd_en | input | 1 | Read enable flag |
| wr_en | input | 1 | Write enable flag |
| ex_en | input | 1 | Execute enable flag |
| gate_cnt | input | 4 | Number of gate words at the start of the segment |
| val_ring | input | 3 | Ring the access is validated in |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| word_ofs | input | 4 | Word offset of the reference |
| allow | output | 1 | Access granted |
| trap | output | 1 | Access violation |
| trap_cause | output | 3 | Cause code per R8 |
| in_gate_ext | output | 1 | Validation ring lies in the gate extension |
| gate_hit | output | 1 | Offset is a gate location |
| gate_entry_ok | output | 1 | A gated entry from this ring would be legal |

## Verification
Every output is combinational, so each result is due in the same cycle its stimulus is applied, with no register on the path. The bench drives a new vector just after a rising clock edge and compares all outputs at the following falling edge. This leaves half a period for the logic to settle, and no check depends on the order of processes at an edge. The sweeps cover every descriptor ordering, every ring and every access kind with rotating flags, then every flag combination on one descriptor, then every gate count against every offset.

// File: rtl/ring_pkg.sv
// Package: shared encodings for the ring bracket checker.
// Assumes rings are small unsigned numbers with 0 the most privileged.
package ring_pkg;

    localparam int RING_W = 3;
    localparam int KIND_W = 2;
    localparam int CAUSE_W = 3;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_READ_BR  = 3'd1,
        CAUSE_WRITE_BR = 3'd2,
        CAUSE_EXEC_BR  = 3'd3,
        CAUSE_FLAG_OFF = 3'd4,
        CAUSE_MALFORM  = 3'd5,
        CAUSE_BAD_KIND = 3'd6
    } cause_e;

endpackage

// File: rtl/ring_order_check.sv
// Module: ring_order_check
// Flags a descriptor whose three ring limits are not in non-decreasing
// order. Assumes all limits are unsigned ring numbers of equal width.
module ring_order_check #(
    parameter int RING_W = 3
) (
    input  logic [RING_W-1:0] wr_top,
    input  logic [RING_W-1:0] rd_top,
    input  logic [RING_W-1:0] gate_top,
    output logic              malformed
);

    // Purpose: a descriptor is malformed when any adjacent pair is inverted.
    always_comb begin
        malformed = (wr_top > rd_top) || (rd_top > gate_top);
    end

endmodule

// File: rtl/ring_bracket_eval.sv
// Module: ring_bracket_eval
// Builds one bracket lane per legal access kind (low bound, high bound,
// enable flag) and selects the lane named by the access kind. Assumes the
// descriptor ordering is checked elsewhere; an illegal kind grants nothing.
module ring_bracket_eval
    import ring_pkg::*;
#(
    parameter int RING_W = 3
) (
    input  logic [RING_W-1:0] wr_top,
    input  logic [RING_W-1:0] rd_top,
    input  logic [RING_W-1:0] val_ring,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              ex_en,
    input  logic [1:0]        acc_kind,
    output logic              kind_ok,
    output logic              flag_ok,
    output logic              bracket_ok,
    output logic              grant
);

    localparam int LANES = 3;

    logic [RING_W-1:0] lane_lo [LANES];
    logic [RING_W-1:0] lane_hi [LANES];
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  lane_in;

    // Purpose: lane 0 read (0..rd_top), lane 1 write (0..wr_top),
    // lane 2 fetch (wr_top..rd_top, floor shared with the write top).
    always_comb begin
        lane_lo[0] = '0;
        lane_hi[0] = rd_top;
        lane_en[0] = rd_en;
        lane_lo[1] = '0;
        lane_hi[1] = wr_top;
        lane_en[1] = wr_en;
        lane_lo[2] = wr_top;
        lane_hi[2] = rd_top;
        lane_en[2] = ex_en;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Purpose: range test of the validation ring against lane k.
        always_comb begin
            lane_in[k] = (val_ring >= lane_lo[k]) && (val_ring <= lane_hi[k]);
        end
    end

    // Purpose: pick the lane selected by the access kind.
    always_comb begin
        kind_ok    = 1'b1;
        flag_ok    = 1'b0;
        bracket_ok = 1'b0;
        case (acc_kind_e'(acc_kind))
            ACC_READ: begin
                flag_ok    = lane_en[0];
                bracket_ok = lane_in[0];
            end
            ACC_WRITE: begin
                flag_ok    = lane_en[1];
                bracket_ok = lane_in[1];
            end
            ACC_FETCH: begin
                flag_ok    = lane_en[2];
                bracket_ok = lane_in[2];
            end
            default: kind_ok = 1'b0;
        endcase
        grant = kind_ok && flag_ok && bracket_ok;
    end

endmodule

// File: rtl/ring_gate_locate.sv
// Module: ring_gate_locate
// Decides whether the validation ring lies in the gate extension and
// whether the word offset falls inside the gate block at the segment
// start. Assumes gates are packed from offset 0 upward.
module ring_gate_locate #(
    parameter int RING_W = 3,
    parameter int GC_W   = 4,
    parameter int OFS_W  = 4
) (
    input  logic [RING_W-1:0] rd_top,
    input  logic [RING_W-1:0] gate_top,
    input  logic [RING_W-1:0] val_ring,
    input  logic [GC_W-1:0]   gate_cnt,
    input  logic [OFS_W-1:0]  word_ofs,
    output logic              in_gate_ext,
    output logic              gate_hit
);

    localparam int CMP_W = (GC_W > OFS_W) ? GC_W : OFS_W;

    logic [CMP_W-1:0] ofs_x;
    logic [CMP_W-1:0] cnt_x;

    // Purpose: zero-extend both operands to a common compare width.
    always_comb begin
        ofs_x = CMP_W'(word_ofs);
        cnt_x = CMP_W'(gate_cnt);
    end

    // Purpose: ring range test above the read top and offset test.
    always_comb begin
        in_gate_ext = (val_ring > rd_top) && (val_ring <= gate_top);
        gate_hit    = ofs_x < cnt_x;
    end

endmodule

// File: rtl/ring_bracket_checker.sv
// Module: ring_bracket_checker (top)
// Validates one reference against a ring-bracket descriptor and returns
// grant or trap with a prioritised cause, plus gate-extension reporting.
// Assumes the descriptor is already fetched; purely combinational.
module ring_bracket_checker
    import ring_pkg::*;
#(
    parameter int RING_W = 3,
    parameter int GC_W   = 4,
    parameter int OFS_W  = 4
) (
    input  logic [RING_W-1:0] wr_top,
    input  logic [RING_W-1:0] rd_top,
    input  logic [RING_W-1:0] gate_top,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              ex_en,
    input  logic [GC_W-1:0]   gate_cnt,
    input  logic [RING_W-1:0] val_ring,
    input  logic [1:0]        acc_kind,
    input  logic [OFS_W-1:0]  word_ofs,
    output logic              allow,
    output logic              trap,
    output logic [2:0]        trap_cause,
    output logic              in_gate_ext,
    output logic              gate_hit,
    output logic              gate_entry_ok
);

    logic malformed;
    logic kind_ok;
    logic flag_ok;
    logic bracket_ok;
    logic grant;
    cause_e cause;

    ring_order_check #(.RING_W(RING_W)) u_order (
        .wr_top    (wr_top),
        .rd_top    (rd_top),
        .gate_top  (gate_top),
        .malformed (malformed)
    );

    ring_bracket_eval #(.RING_W(RING_W)) u_eval (
        .wr_top     (wr_top),
        .rd_top     (rd_top),
        .val_ring   (val_ring),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .ex_en      (ex_en),
        .acc_kind   (acc_kind),
        .kind_ok    (kind_ok),
        .flag_ok    (flag_ok),
        .bracket_ok (bracket_ok),
        .grant      (grant)
    );

    ring_gate_locate #(.RING_W(RING_W), .GC_W(GC_W), .OFS_W(OFS_W)) u_gate (
        .rd_top      (rd_top),
        .gate_top    (gate_top),
        .val_ring    (val_ring),
        .gate_cnt    (gate_cnt),
        .word_ofs    (word_ofs),
        .in_gate_ext (in_gate_ext),
        .gate_hit    (gate_hit)
    );

    // Purpose: priority encoding of the violation cause.
    always_comb begin
        if (malformed) begin
            cause = CAUSE_MALFORM;
        end else if (!kind_ok) begin
            cause = CAUSE_BAD_KIND;
        end else if (!flag_ok) begin
            cause = CAUSE_FLAG_OFF;
        end else if (!bracket_ok) begin
            case (acc_kind_e'(acc_kind))
                ACC_READ:  cause = CAUSE_READ_BR;
                ACC_WRITE: cause = CAUSE_WRITE_BR;
                default:   cause = CAUSE_EXEC_BR;
            endcase
        end else begin
            cause = CAUSE_NONE;
        end
    end

    // Purpose: drive grant from the lane path and trap from the cause path.
    always_comb begin
        allow         = grant && !malformed;
        trap          = (cause != CAUSE_NONE);
        trap_cause    = cause;
        gate_entry_ok = in_gate_ext && gate_hit && ex_en && !malformed;
    end

endmodule

// File: rtl/ring_bracket_checker_sva.sv
// Module: ring_bracket_checker_sva
// Checker bound to the top; immediate assertions on the settled outputs.
// Assumes inputs are stable when outputs are evaluated.
module ring_bracket_checker_sva #(
    parameter int RING_W = 3,
    parameter int GC_W   = 4,
    parameter int OFS_W  = 4
) (
    input logic [RING_W-1:0] wr_top,
    input logic [RING_W-1:0] rd_top,
    input logic [RING_W-1:0] gate_top,
    input logic              rd_en,
    input logic              wr_en,
    input logic              ex_en,
    input logic [GC_W-1:0]   gate_cnt,
    input logic [RING_W-1:0] val_ring,
    input logic [1:0]        acc_kind,
    input logic [OFS_W-1:0]  word_ofs,
    input logic              allow,
    input logic              trap,
    input logic [2:0]        trap_cause,
    input logic              in_gate_ext,
    input logic              gate_hit,
    input logic              gate_entry_ok
);

    // Purpose: relate grant, trap and cause to the descriptor and request.
    always_comb begin
        a_r9_allow_xor_trap: assert (allow != trap);
        a_r9_cause_zero_on_allow: assert (allow == (trap_cause == 3'd0));
        a_r6_malformed_blocks: assert (!((wr_top > rd_top) || (rd_top > gate_top))
                                       || (!allow && !gate_entry_ok && trap_cause == 3'd5));
        a_r1_write_in_bracket: assert (!(allow && acc_kind == 2'd1)
                                       || (wr_en && val_ring <= wr_top));
        a_r2_read_in_bracket: assert (!(allow && acc_kind == 2'd0)
                                      || (rd_en && val_ring <= rd_top));
        a_r3_fetch_in_bracket: assert (!(allow && acc_kind == 2'd2)
                                       || (ex_en && val_ring >= wr_top && val_ring <= rd_top));
        a_r3_no_fetch_from_ext: assert (!(in_gate_ext && acc_kind == 2'd2) || !allow);
        a_r7_bad_kind_denied: assert (acc_kind != 2'd3 || !allow);
        a_r5_entry_needs_gate: assert (!gate_entry_ok || (in_gate_ext && gate_hit && ex_en));
        a_r5_no_gates_no_hit: assert (gate_cnt != '0 || !gate_hit);
        a_r5_offset_zero_hit: assert (!(word_ofs == '0 && gate_cnt != '0) || gate_hit);
    end

endmodule

bind ring_bracket_checker ring_bracket_checker_sva #(
    .RING_W(RING_W), .GC_W(GC_W), .OFS_W(OFS_W)
) u_sva (
    .wr_top        (wr_top),
    .rd_top        (rd_top),
    .gate_top      (gate_top),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .ex_en         (ex_en),
    .gate_cnt      (gate_cnt),
    .val_ring      (val_ring),
    .acc_kind      (acc_kind),
    .word_ofs      (word_ofs),
    .allow         (allow),
    .trap          (trap),
    .trap_cause    (trap_cause),
    .in_gate_ext   (in_gate_ext),
    .gate_hit      (gate_hit),
    .gate_entry_ok (gate_entry_ok)
);

// File: tb/ring_bracket_checker_tb.sv
// Bench: sweeps descriptors, rings, kinds, flags, gate counts and offsets;
// expected values computed arithmetically from the requirements.
module ring_bracket_checker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wr_top = '0, rd_top = '0, gate_top = '0, val_ring = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, ex_en = 1'b0;
    logic [3:0] gate_cnt = '0, word_ofs = '0;
    logic [1:0] acc_kind = '0;
    logic       allow, trap, in_gate_ext, gate_hit, gate_entry_ok;
    logic [2:0] trap_cause;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_bracket_checker u_dut (
        .wr_top(wr_top), .rd_top(rd_top), .gate_top(gate_top),
        .rd_en(rd_en), .wr_en(wr_en), .ex_en(ex_en),
        .gate_cnt(gate_cnt), .val_ring(val_ring), .acc_kind(acc_kind),
        .word_ofs(word_ofs), .allow(allow), .trap(trap),
        .trap_cause(trap_cause), .in_gate_ext(in_gate_ext),
        .gate_hit(gate_hit), .gate_entry_ok(gate_entry_ok)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (w%0d r%0d g%0d ring%0d kind%0d f%0d%0d%0d cnt%0d ofs%0d)",
                     req, what, act, exp, wr_top, rd_top, gate_top, val_ring, acc_kind,
                     rd_en, wr_en, ex_en, gate_cnt, word_ofs);
        end
    endtask

    // Drive after a rising edge, compare at the following falling edge.
    task automatic apply(input int w, input int r, input int g, input int ring,
                         input int kind, input int flags, input int cnt, input int ofs);
        int   e_cause;
        bit   malf, flag, inbr, e_ext, e_hit;
        string req;
        @(posedge clk);
        wr_top = 3'(w); rd_top = 3'(r); gate_top = 3'(g); val_ring = 3'(ring);
        acc_kind = 2'(kind); rd_en = flags[0]; wr_en = flags[1]; ex_en = flags[2];
        gate_cnt = 4'(cnt); word_ofs = 4'(ofs);
        malf = (w > r) || (r > g);
        flag = (kind == 0) ? flags[0] : (kind == 1) ? flags[1] : flags[2];
        inbr = (kind == 0) ? (ring <= r) : (kind == 1) ? (ring <= w) : (ring >= w && ring <= r);
        if (malf)            begin e_cause = 5; req = "R6"; end
        else if (kind == 3)  begin e_cause = 6; req = "R7"; end
        else if (!flag)      begin e_cause = 4; req = "R8"; end
        else if (!inbr)      begin e_cause = kind + 1; req = (kind == 0) ? "R2" : (kind == 1) ? "R1" : "R3"; end
        else                 begin e_cause = 0; req = (kind == 0) ? "R2" : (kind == 1) ? "R1" : "R3"; end
        e_ext = (ring > r) && (ring <= g);
        e_hit = ofs < cnt;
        @(negedge clk);
        check(req, "trap_cause", int'(trap_cause), e_cause);
        check("R9", "allow", int'(allow), int'(e_cause == 0));
        check("R9", "trap", int'(trap), int'(e_cause != 0));
        check("R4", "in_gate_ext", int'(in_gate_ext), int'(e_ext));
        check("R5", "gate_hit", int'(gate_hit), int'(e_hit));
        check("R5", "gate_entry_ok", int'(gate_entry_ok), int'(e_ext && e_hit && flags[2] && !malf));
    endtask

    initial begin
        int iter = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: read with flags off traps with cause 4 (R8).
        @(negedge clk);
        check("R8", "idle trap_cause", int'(trap_cause), 4);
        check("R9", "idle allow", int'(allow), 0);
        // Directed corners: fetch at floor, fetch from extension (R3), write at top (R1).
        apply(2, 4, 6, 2, 2, 7, 0, 0);
        apply(2, 4, 6, 5, 2, 7, 2, 1);
        apply(2, 4, 6, 1, 2, 7, 0, 0);
        apply(2, 4, 6, 2, 1, 7, 0, 0);
        apply(2, 4, 6, 3, 1, 7, 0, 0);
        // R6, R7 and priority corners.
        apply(5, 4, 6, 0, 3, 0, 1, 0);
        apply(1, 4, 6, 0, 3, 7, 1, 0);
        // Every descriptor ordering, ring and kind with rotating flags.
        for (int w = 0; w < 8; w++)
            for (int r = 0; r < 8; r++)
                for (int g = 0; g < 8; g++)
                    for (int ring = 0; ring < 8; ring++)
                        for (int kind = 0; kind < 4; kind++) begin
                            int fl;
                            fl = (iter ^ (iter >> 3) ^ (iter >> 6)) & 7;
                            apply(w, r, g, ring, kind, fl, (iter >> 2) & 15, iter & 15);
                            iter++;
                        end
        // Every flag combination on one well-formed descriptor.
        for (int fl = 0; fl < 8; fl++)
            for (int ring = 0; ring < 8; ring++)
                for (int kind = 0; kind < 4; kind++)
                    apply(1, 3, 5, ring, kind, fl, 3, 2);
        // Every gate count against every offset, from gate and non-gate rings.
        for (int cnt = 0; cnt < 16; cnt++)
            for (int ofs = 0; ofs < 16; ofs++)
                for (int ring = 0; ring < 8; ring++)
                    apply(1, 2, 5, ring, 2, ((cnt + ofs) & 1) ? 7 : 3, cnt, ofs);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule